// File: doc/BRIEF.md
# Every-Nth Packet Sampling Pipeline

This block takes a stream of packets, at most one per clock, each carrying a source address and a valid strobe. It marks one packet in every `PERIOD` for sampling. The default is one in ten. Each packet leaves the block two cycles after it entered, in the same order. It carries its source address unchanged and a sample field. The sample field holds the source address on a selected packet and zero on every other packet.

The work is split across two pipeline stages. The first stage owns a persistent packet counter. In one cycle it reads the counter, compares the old value against `PERIOD-1`, and writes back either zero or the incremented value. It passes the result of that comparison forward as a one-bit temporary field, next to the source address. The second stage holds no state. It only forms the sample field from the forwarded flag and address. Any logic that collects or exports the sampled packets sits outside this block.

The asynchronous active-low reset is released through a two-flop synchronizer. Input packets are not accepted until that synchronizer has let go.

Top module: `nth_sampler`

## Requirements
- R1: While reset is asserted, and right after it, `pkt_out_vld` is 0. The counter starts at 0, so the first packet sampled after reset is packet number `PERIOD` (the tenth by default).
- R2: `pkt_out_vld` equals `pkt_in_vld` from exactly two clock cycles earlier.
- R3: `pkt_out_src` equals the `pkt_in_src` of the packet that entered two cycles earlier.
- R4: `pkt_out_smp` equals the packet's source address when the counter value read for that packet was `PERIOD-1`. Otherwise it is 0.
- R5: After a sampled packet the counter returns to 0. The next packet sampled is exactly `PERIOD` valid packets later, and this repeats across many periods.
- R6: Cycles with `pkt_in_vld` low do not change the counter, whatever `pkt_in_src` holds. Sample positions count valid packets only, however the idle cycles fall between them.
- R7: Packets sent back to back, one per cycle, all come out on consecutive cycles with no loss or reordering. Each one sees the counter update made for the packet before it.
- R8: Asserting reset in the middle of a stream clears the counter. After reset the count starts over from packet one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_in_vld | input | 1 | A packet is present this cycle |
| pkt_in_src | input | SRC_W (32) | Source address of the incoming packet |
| pkt_out_vld | output | 1 | A processed packet is present this cycle |
| pkt_out_src | output | SRC_W (32) | Source address of the outgoing packet |
| pkt_out_smp | output | SRC_W (32) | Sample field: the source address on a selected packet, else 0 |

## Verification
The bench keeps its own count of valid packets, computed arithmetically. It runs that count across several wrap points with back-to-back traffic and then with idle gaps from zero to three cycles. A design that counted idle cycles, or whose compare was off by one, would sample at the wrong position, for example the ninth or eleventh packet. Idle cycles carry nonzero junk on the address bus, which exposes any design that lets idle data leak into the counter or the outputs. A mid-stream reset follows, and the bench checks that the tenth packet after it is the one sampled. A counter that survived reset would mark an earlier packet.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

  parameter int unsigned DEF_SRC_W  = 32;
  parameter int unsigned DEF_PERIOD = 10;

  // Action taken on the persistent counter in the stateful stage
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_WRAP = 2'd2
  } cnt_act_e;

endpackage

// File: rtl/sampler_rst_sync.sv
module sampler_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sampler_count_stage.sv
module sampler_count_stage
  import sampler_pkg::*;
#(
  parameter int unsigned SRC_W  = DEF_SRC_W,
  parameter int unsigned PERIOD = DEF_PERIOD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [SRC_W-1:0] in_src,
  output logic             s1_vld,
  output logic             s1_hit,
  output logic [SRC_W-1:0] s1_src
);

  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             hit_d;
  cnt_act_e         act;

  // Atomic read-compare-write on the persistent counter
  always_comb begin
    act   = CNT_HOLD;
    hit_d = 1'b0;
    if (in_vld) begin
      hit_d = (cnt_q == LAST);
      act   = hit_d ? CNT_WRAP : CNT_INC;
    end
  end

  always_comb begin
    cnt_en = (act != CNT_HOLD);
    unique case (act)
      CNT_WRAP: cnt_d = '0;
      CNT_INC:  cnt_d = cnt_q + 1'b1;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      s1_vld <= 1'b0;
      s1_hit <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_hit <= hit_d;
      end
    end
  end

  // Data path register: no reset, loaded only with a packet
  always_ff @(posedge clk) begin
    if (in_vld) begin
      s1_src <= in_src;
    end
  end

endmodule

// File: rtl/sampler_mark_stage.sv
module sampler_mark_stage #(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_vld,
  input  logic             s1_hit,
  input  logic [SRC_W-1:0] s1_src,
  output logic             out_vld,
  output logic [SRC_W-1:0] out_src,
  output logic [SRC_W-1:0] out_smp
);

  logic [SRC_W-1:0] smp_d;

  always_comb begin
    smp_d = s1_hit ? s1_src : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld) begin
      out_src <= s1_src;
      out_smp <= smp_d;
    end
  end

endmodule

// File: rtl/nth_sampler.sv
module nth_sampler
  import sampler_pkg::*;
#(
  parameter int unsigned SRC_W  = DEF_SRC_W,
  parameter int unsigned PERIOD = DEF_PERIOD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_in_vld,
  input  logic [SRC_W-1:0] pkt_in_src,
  output logic             pkt_out_vld,
  output logic [SRC_W-1:0] pkt_out_src,
  output logic [SRC_W-1:0] pkt_out_smp
);

  logic             rst_n_int;
  logic             s1_vld;
  logic             s1_hit;
  logic [SRC_W-1:0] s1_src;
  logic             acc_vld;

  sampler_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Packets arriving while the internal reset is held are dropped
  assign acc_vld = pkt_in_vld & rst_n_int;

  sampler_count_stage #(.SRC_W(SRC_W), .PERIOD(PERIOD)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .in_vld (acc_vld),
    .in_src (pkt_in_src),
    .s1_vld (s1_vld),
    .s1_hit (s1_hit),
    .s1_src (s1_src)
  );

  sampler_mark_stage #(.SRC_W(SRC_W)) u_mark (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .s1_vld  (s1_vld),
    .s1_hit  (s1_hit),
    .s1_src  (s1_src),
    .out_vld (pkt_out_vld),
    .out_src (pkt_out_src),
    .out_smp (pkt_out_smp)
  );

endmodule

// File: rtl/sampler_chk.sv
module sampler_chk #(
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned PERIOD = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_in_vld,
  input logic [SRC_W-1:0] pkt_in_src,
  input logic             pkt_out_vld,
  input logic [SRC_W-1:0] pkt_out_src,
  input logic [SRC_W-1:0] pkt_out_smp
);

  logic [2:0] arm_q;
  int unsigned ocnt_q;
  logic armed;

  assign armed = (arm_q >= 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= '0;
      ocnt_q <= 0;
    end else begin
      if (arm_q != 3'd7) arm_q <= arm_q + 3'd1;
      if (pkt_out_vld) ocnt_q <= (ocnt_q == PERIOD - 1) ? 0 : ocnt_q + 1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !pkt_out_vld); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pkt_out_vld == $past(pkt_in_vld, 2))); // R2

  AST_SRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && pkt_out_vld) |-> (pkt_out_src == $past(pkt_in_src, 2))); // R3

  AST_SAMPLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_out_vld |-> (pkt_out_smp == '0 || pkt_out_smp == pkt_out_src)); // R4

  AST_SAMPLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_out_vld && ocnt_q == PERIOD - 1) |-> (pkt_out_smp == pkt_out_src)); // R5

  AST_SAMPLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_out_vld && ocnt_q != PERIOD - 1) |-> (pkt_out_smp == '0)); // R6

endmodule

bind nth_sampler sampler_chk #(.SRC_W(SRC_W), .PERIOD(PERIOD)) u_chk (.*);

// File: tb/test_nth_sampler.sv
module test_nth_sampler;

  localparam int unsigned SRC_W  = 32;
  localparam int unsigned PERIOD = 10;

  logic             clk;
  logic             rst_n;
  logic             pkt_in_vld;
  logic [SRC_W-1:0] pkt_in_src;
  logic             pkt_out_vld;
  logic [SRC_W-1:0] pkt_out_src;
  logic [SRC_W-1:0] pkt_out_smp;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int unsigned idx = 0;

  logic             e1_v, e2_v;
  logic [SRC_W-1:0] e1_s, e2_s, e1_m, e2_m;
  string            e1_t, e2_t;

  nth_sampler #(.SRC_W(SRC_W), .PERIOD(PERIOD)) i_nth_sampler (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [SRC_W-1:0] act, input logic [SRC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_pipe();
    e1_v = 1'b0; e2_v = 1'b0;
    e1_s = '0; e2_s = '0; e1_m = '0; e2_m = '0;
    e1_t = "R1"; e2_t = "R1";
  endtask

  // One cycle: check what entered two cycles ago, then drive a new input
  task automatic step(input logic v, input logic [SRC_W-1:0] s, input string tag);
    @(negedge clk);
    check(e2_t, "out_vld", {31'd0, pkt_out_vld}, {31'd0, e2_v});
    if (e2_v) begin
      check("R3", "out_src", pkt_out_src, e2_s);
      check(e2_m != '0 ? "R4" : e2_t, "out_smp", pkt_out_smp, e2_m);
    end
    e2_v = e1_v; e2_s = e1_s; e2_m = e1_m; e2_t = e1_t;
    e1_v = v; e1_s = s; e1_t = tag;
    e1_m = (v && (idx % PERIOD) == PERIOD - 1) ? s : '0;
    if (v) idx++;
    pkt_in_vld = v;
    pkt_in_src = s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pkt_in_vld = 1'b0;
    clear_pipe();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", "out_vld in reset", {31'd0, pkt_out_vld}, '0);
    end
    rst_n = 1'b1;
    idx = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 32'hDEAD_0000 + i, "R1");
  endtask

  initial begin
    rst_n = 1'b0;
    pkt_in_vld = 1'b0;
    pkt_in_src = '0;
    clear_pipe();
    do_reset();

    // Back-to-back stream across several wraps
    for (int i = 0; i < 35; i++) step(1'b1, 32'hA000_0000 + 32'(i) * 32'h0101_0101 + 1, "R7");
    for (int i = 0; i < 2; i++) step(1'b0, 32'h5555_5555, "R5");

    // Idle gaps of 0..3 cycles with junk on the address bus
    for (int g = 0; g < 4; g++) begin
      for (int i = 0; i < 23; i++) begin
        step(1'b1, 32'hB000_0000 + 32'(g << 16) + 32'(i) + 1, "R6");
        for (int k = 0; k < ((i + g) % 4); k++) step(1'b0, 32'hFFFF_FFFF - 32'(k), "R6");
      end
    end
    for (int i = 0; i < 2; i++) step(1'b0, '0, "R6");

    // Mid-stream reset after a partial period
    for (int i = 0; i < 4; i++) step(1'b1, 32'hC000_0000 + 32'(i) + 1, "R5");
    do_reset();
    for (int i = 0; i < 25; i++) step(1'b1, 32'hD000_0000 + 32'(i) + 1, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule